// File: doc/BRIEF.md
# Index/Data Window to System Bus Bridge

This block lets a host with only a narrow byte-wide I/O path reach a 32-bit memory-mapped system bus. The host sees two byte ports: an index port, which selects an internal register, and a data port, which reads or writes the selected register. Behind that window sit staging registers for a target address and a data word, a transfer-size register and a trigger register. Writing the trigger with a fixed code issues one bus write. Reading the trigger issues one bus read, and the returned word lands in the data staging registers.

The window stays closed until the host writes a two-byte key sequence to the index port. A separate lock code closes it again. The bridge registers belong to one logical device, which must be selected through a device-select register. The device also has an enable bit that gates every bus cycle. While a bus cycle is in flight, the host-side ready output stays low. A host that waits for ready therefore always sees completed results on its next access.

Top module: `idx_bus_bridge`

## Requirements
- R1: After reset the window is locked, `h_ready_o` is 1, `m_req_o` is 0, and the device select, enable, size, address and data registers are all zero.
- R2: The window opens only after two index-port (address 0x2e) writes of 0xa5 in a row. Any other index write in between breaks the pair. While the window is locked, data-port (address 0x2f) writes are ignored, and reads of either port return 0. While it is open, an index-port read returns the last value written to the index port.
- R3: When the window is open, an index write of 0xaa closes it. After that, data-port writes are ignored and data-port reads return 0 until the next double 0xa5.
- R4: Register 0x07 holds the device select and is always readable and writable when the window is open. Registers 0x30, 0xf0–0xf8 and 0xfe respond only while the device select equals 0x0d. Otherwise their writes are ignored and their reads return 0.
- R5: Bit 0 of register 0x30 is the enable bit, and it reads back alone with bits 7:1 as zero. While the enable bit is 0, neither kind of trigger starts a bus cycle.
- R6: Registers 0xf0, 0xf1, 0xf2 and 0xf3 hold target address bits 31:24, 23:16, 15:8 and 7:0, in that order, and read back what was written.
- R7: Writing 0xcf to register 0xfe starts a bus write. On the next cycle `m_req_o` rises with `m_we_o`=1, the staged address and the staged size. Any other value written to 0xfe starts nothing.
- R8: Reading register 0xfe returns 0x00 and starts a bus read with `m_we_o`=0. The returned word is loaded into 0xf4 (bits 31:24) through 0xf7 (bits 7:0).
- R9: Register 0xf8 holds the size in bits 1:0 and drives `m_size_o`. Size 0 selects a byte access, 1 a halfword and 2 or 3 a word. For a byte access the write data is staged bits 7:0 with the rest zero, and for a halfword it is bits 15:0 with the rest zero. Read data is zero-extended the same way.
- R10: Once `m_req_o` is high it stays high, with address, direction and write data stable, until a cycle with `m_ready_i`=1. `h_ready_o` is 0 whenever `m_req_o` is 1. Host strobes made while `h_ready_o` is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_addr_i | input | 16 | Host I/O address |
| h_wr_i | input | 1 | Host write strobe, one cycle per access |
| h_rd_i | input | 1 | Host read strobe, one cycle per access |
| h_wdata_i | input | 8 | Host write byte |
| h_rdata_o | output | 8 | Host read byte, valid in the cycle of `h_rd_i` |
| h_ready_o | output | 1 | High when a host strobe will be accepted |
| m_req_o | output | 1 | System bus request |
| m_addr_o | output | 32 | System bus address |
| m_we_o | output | 1 | System bus direction, 1 for a write |
| m_size_o | output | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| m_wdata_o | output | 32 | System bus write data |
| m_ready_i | input | 1 | System bus completion |
| m_rdata_i | input | 32 | System bus read data |

## Verification
A wrong key-tracker state appears at the data port straight away, as a zero read that should hold a value, or as a staged byte that changed when it should have been held. A wrong staging lane or wrong size mask appears on `m_addr_o` or `m_wdata_o` in the first cycle of the bus request. A wrong read-data path appears on the first data-port read after `h_ready_o` returns high. A stuck or early-clearing bus state shows as `h_ready_o` high during a request, or as an extra or missing bus transaction, within one cycle of the completion.

// File: rtl/idx_bridge_pkg.sv
package idx_bridge_pkg;
  typedef enum logic [0:0] {M_IDLE, M_BUSY} mst_state_e;

  localparam logic [7:0] REG_LDN  = 8'h07;
  localparam logic [7:0] REG_ENA  = 8'h30;
  localparam logic [7:0] REG_ADR0 = 8'hf0;
  localparam logic [7:0] REG_DAT0 = 8'hf4;
  localparam logic [7:0] REG_SIZE = 8'hf8;
  localparam logic [7:0] REG_TRIG = 8'hfe;
  localparam logic [7:0] TRIG_KEY = 8'hcf;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/idx_cfg_gate.sv
module idx_cfg_gate #(
  parameter logic [7:0] UNLOCK_KEY = 8'ha5,
  parameter logic [7:0] LOCK_KEY   = 8'haa
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_we_i,
  input  logic [7:0] wdata_i,
  output logic       unlocked_o,
  output logic [7:0] index_o
);
  logic       armed_q, unlocked_q;
  logic [7:0] index_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      unlocked_q <= 1'b0;
      index_q    <= '0;
    end else if (idx_we_i) begin
      index_q <= wdata_i;
      if (unlocked_q) begin
        armed_q <= 1'b0;
        if (wdata_i == LOCK_KEY) unlocked_q <= 1'b0;
      end else if (wdata_i == UNLOCK_KEY) begin
        if (armed_q) begin
          unlocked_q <= 1'b1;
          armed_q    <= 1'b0;
        end else begin
          armed_q <= 1'b1;
        end
      end else begin
        armed_q <= 1'b0;
      end
    end
  end

  assign unlocked_o = unlocked_q;
  assign index_o    = index_q;

  AST_UNLOCK_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_q) |-> $past(idx_we_i && wdata_i == UNLOCK_KEY)); // R2
  AST_LOCK_NEEDS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(unlocked_q) |-> $past(idx_we_i && wdata_i == LOCK_KEY)); // R3
endmodule

// File: rtl/idx_bridge_regs.sv
module idx_bridge_regs
  import idx_bridge_pkg::*;
#(
  parameter int         ADDR_W = 32,
  parameter int         DATA_W = 32,
  parameter logic [7:0] DEV_ID = 8'h0d
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [7:0]        num_i,
  input  logic [7:0]        wdata_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic [7:0]        rdata_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [1:0]        size_o,
  output logic              en_o,
  output logic              start_wr_o,
  output logic              start_rd_o
);
  localparam int NAB = ADDR_W / 8;
  localparam int NDB = DATA_W / 8;

  logic [7:0] ldn_q;
  logic       en_q;
  logic [1:0] size_q;
  logic [7:0] adr_q [NAB];
  logic [7:0] dat_q [NDB];
  logic       dev_sel;

  assign dev_sel = (ldn_q == DEV_ID);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ldn_q  <= '0;
      en_q   <= 1'b0;
      size_q <= '0;
      for (int i = 0; i < NAB; i++) adr_q[i] <= '0;
      for (int i = 0; i < NDB; i++) dat_q[i] <= '0;
    end else begin
      if (we_i && num_i == REG_LDN) ldn_q <= wdata_i;
      if (we_i && dev_sel) begin
        if (num_i == REG_ENA)  en_q   <= wdata_i[0];
        if (num_i == REG_SIZE) size_q <= wdata_i[1:0];
        for (int i = 0; i < NAB; i++)
          if (num_i == REG_ADR0 + 8'(i)) adr_q[i] <= wdata_i;
        for (int i = 0; i < NDB; i++)
          if (num_i == REG_DAT0 + 8'(i)) dat_q[i] <= wdata_i;
      end
      if (load_i)
        for (int i = 0; i < NDB; i++) dat_q[i] <= load_data_i[DATA_W-1-8*i -: 8];
    end
  end

  // index 0 is the most significant byte of each staged word
  for (genvar g = 0; g < NAB; g++) begin : g_adr_lane
    assign addr_o[ADDR_W-1-8*g -: 8] = adr_q[g];
  end
  for (genvar g = 0; g < NDB; g++) begin : g_dat_lane
    assign data_o[DATA_W-1-8*g -: 8] = dat_q[g];
  end

  always_comb begin
    rdata_o = '0;
    if (num_i == REG_LDN) begin
      rdata_o = ldn_q;
    end else if (dev_sel) begin
      if (num_i == REG_ENA)  rdata_o = {7'd0, en_q};
      if (num_i == REG_SIZE) rdata_o = {6'd0, size_q};
      for (int i = 0; i < NAB; i++)
        if (num_i == REG_ADR0 + 8'(i)) rdata_o = adr_q[i];
      for (int i = 0; i < NDB; i++)
        if (num_i == REG_DAT0 + 8'(i)) rdata_o = dat_q[i];
    end
  end

  assign size_o     = size_q;
  assign en_o       = en_q;
  assign start_wr_o = we_i && dev_sel && en_q && num_i == REG_TRIG && wdata_i == TRIG_KEY;
  assign start_rd_o = re_i && dev_sel && en_q && num_i == REG_TRIG;

  AST_LOAD_NO_HOST_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !we_i); // R10
endmodule

// File: rtl/idx_sys_master.sv
module idx_sys_master
  import idx_bridge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_wr_i,
  input  logic              start_rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        size_i,
  input  logic              m_ready_i,
  input  logic [DATA_W-1:0] m_rdata_i,
  output logic              m_req_o,
  output logic [ADDR_W-1:0] m_addr_o,
  output logic              m_we_o,
  output logic [1:0]        m_size_o,
  output logic [DATA_W-1:0] m_wdata_o,
  output logic              busy_o,
  output logic              done_rd_o,
  output logic [DATA_W-1:0] rd_data_o
);
  function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return DATA_W'(8'hff);
      SZ_HALF: return DATA_W'(16'hffff);
      default: return '1;
    endcase
  endfunction

  mst_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        size_q;
  logic              we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= M_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      size_q  <= '0;
      we_q    <= 1'b0;
    end else begin
      case (state_q)
        M_IDLE: if (start_wr_i || start_rd_i) begin
          state_q <= M_BUSY;
          addr_q  <= addr_i;
          wdata_q <= data_i & lane_mask(size_i);
          size_q  <= size_i;
          we_q    <= start_wr_i;
        end
        M_BUSY: if (m_ready_i) state_q <= M_IDLE;
        default: state_q <= M_IDLE;
      endcase
    end
  end

  assign m_req_o   = (state_q == M_BUSY);
  assign m_addr_o  = addr_q;
  assign m_we_o    = we_q;
  assign m_size_o  = size_q;
  assign m_wdata_o = wdata_q;
  assign busy_o    = m_req_o;
  assign done_rd_o = m_req_o && m_ready_i && !we_q;
  assign rd_data_o = m_rdata_i & lane_mask(size_q);

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_req_o && !m_ready_i |=> m_req_o && $stable(m_addr_o) && $stable(m_wdata_o) && $stable(m_we_o)); // R10
  AST_BYTE_WDATA_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_req_o && m_size_o == SZ_BYTE |-> m_wdata_o[DATA_W-1:8] == '0); // R9
endmodule

// File: rtl/idx_bus_bridge.sv
module idx_bus_bridge #(
  parameter int          HADDR_W  = 16,
  parameter logic [15:0] IDX_PORT = 16'h002e,
  parameter logic [15:0] DAT_PORT = 16'h002f,
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter logic [7:0]  DEV_ID   = 8'h0d
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [HADDR_W-1:0] h_addr_i,
  input  logic               h_wr_i,
  input  logic               h_rd_i,
  input  logic [7:0]         h_wdata_i,
  output logic [7:0]         h_rdata_o,
  output logic               h_ready_o,
  output logic               m_req_o,
  output logic [ADDR_W-1:0]  m_addr_o,
  output logic               m_we_o,
  output logic [1:0]         m_size_o,
  output logic [DATA_W-1:0]  m_wdata_o,
  input  logic               m_ready_i,
  input  logic [DATA_W-1:0]  m_rdata_i
);
  logic              busy, accept, idx_hit, dat_hit;
  logic              unlocked, idx_we, reg_we, reg_re;
  logic [7:0]        index, reg_rdata;
  logic [ADDR_W-1:0] st_addr;
  logic [DATA_W-1:0] st_data, rd_data;
  logic [1:0]        st_size;
  logic              en, start_wr, start_rd, done_rd;

  assign accept  = !busy;
  assign idx_hit = (h_addr_i == HADDR_W'(IDX_PORT));
  assign dat_hit = (h_addr_i == HADDR_W'(DAT_PORT));
  assign idx_we  = h_wr_i && accept && idx_hit;
  assign reg_we  = h_wr_i && accept && dat_hit && unlocked;
  assign reg_re  = h_rd_i && accept && dat_hit && unlocked;

  idx_cfg_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_we_i   (idx_we),
    .wdata_i    (h_wdata_i),
    .unlocked_o (unlocked),
    .index_o    (index)
  );

  idx_bridge_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_ID(DEV_ID)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we),
    .re_i        (reg_re),
    .num_i       (index),
    .wdata_i     (h_wdata_i),
    .load_i      (done_rd),
    .load_data_i (rd_data),
    .rdata_o     (reg_rdata),
    .addr_o      (st_addr),
    .data_o      (st_data),
    .size_o      (st_size),
    .en_o        (en),
    .start_wr_o  (start_wr),
    .start_rd_o  (start_rd)
  );

  idx_sys_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_wr_i (start_wr),
    .start_rd_i (start_rd),
    .addr_i     (st_addr),
    .data_i     (st_data),
    .size_i     (st_size),
    .m_ready_i  (m_ready_i),
    .m_rdata_i  (m_rdata_i),
    .m_req_o    (m_req_o),
    .m_addr_o   (m_addr_o),
    .m_we_o     (m_we_o),
    .m_size_o   (m_size_o),
    .m_wdata_o  (m_wdata_o),
    .busy_o     (busy),
    .done_rd_o  (done_rd),
    .rd_data_o  (rd_data)
  );

  always_comb begin
    h_rdata_o = '0;
    if (h_rd_i && accept && unlocked) begin
      if (idx_hit)      h_rdata_o = index;
      else if (dat_hit) h_rdata_o = reg_rdata;
    end
  end

  assign h_ready_o = accept;

  AST_HOST_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_req_o |-> !h_ready_o); // R10
  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(m_req_o) |-> $past(en && unlocked)); // R5
  AST_LOCKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked |-> h_rdata_o == '0); // R2
endmodule

// File: tb/idx_bus_bridge_tb.sv
module idx_bus_bridge_tb;
  localparam logic [15:0] IDX = 16'h002e;
  localparam logic [15:0] DAT = 16'h002f;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] h_addr_i = '0;
  logic        h_wr_i = 1'b0, h_rd_i = 1'b0;
  logic [7:0]  h_wdata_i = '0;
  logic [7:0]  h_rdata_o;
  logic        h_ready_o, m_req_o, m_we_o;
  logic [31:0] m_addr_o, m_wdata_o;
  logic [1:0]  m_size_o;
  logic        m_ready_i = 1'b0;
  logic [31:0] m_rdata_i = '0;

  int nvec = 0, nerr = 0, ntx = 0, lat = 0, wcnt = 0;
  logic [31:0] cap_addr, cap_wdata;
  logic        cap_we;
  logic [1:0]  cap_size;

  always #5 clk_i = ~clk_i;

  idx_bus_bridge u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .h_addr_i(h_addr_i), .h_wr_i(h_wr_i), .h_rd_i(h_rd_i),
    .h_wdata_i(h_wdata_i), .h_rdata_o(h_rdata_o), .h_ready_o(h_ready_o), .m_req_o(m_req_o),
    .m_addr_o(m_addr_o), .m_we_o(m_we_o), .m_size_o(m_size_o), .m_wdata_o(m_wdata_o),
    .m_ready_i(m_ready_i), .m_rdata_i(m_rdata_i)
  );

  function automatic logic [31:0] model_rd(input logic [31:0] a);
    return (a * 32'h9e3779b1) ^ 32'h0f1e2d3c;
  endfunction

  function automatic logic [31:0] msk(input int sz);
    return (sz == 0) ? 32'h0000_00ff : (sz == 1) ? 32'h0000_ffff : 32'hffff_ffff;
  endfunction

  // system-side responder, driven away from the active edge
  always @(negedge clk_i) begin
    if (m_ready_i) begin
      m_ready_i = 1'b0;
    end else if (m_req_o) begin
      if (wcnt >= lat) begin
        m_ready_i = 1'b1;
        m_rdata_i = model_rd(m_addr_o);
        cap_addr  = m_addr_o;
        cap_wdata = m_wdata_o;
        cap_we    = m_we_o;
        cap_size  = m_size_o;
        ntx++;
        wcnt = 0;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    while (!h_ready_o) @(negedge clk_i);
    h_addr_i = a; h_wdata_i = d; h_wr_i = 1'b1;
    @(negedge clk_i);
    h_wr_i = 1'b0;
  endtask

  task automatic io_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk_i);
    while (!h_ready_o) @(negedge clk_i);
    h_addr_i = a; h_rd_i = 1'b1;
    #1 d = h_rdata_o;
    @(negedge clk_i);
    h_rd_i = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] r, input logic [7:0] d);
    io_wr(IDX, r);
    io_wr(DAT, d);
  endtask

  task automatic reg_rd(input logic [7:0] r, output logic [7:0] d);
    io_wr(IDX, r);
    io_rd(DAT, d);
  endtask

  task automatic wait_idle();
    while (!h_ready_o) @(negedge clk_i);
  endtask

  task automatic unlock();
    io_wr(IDX, 8'ha5);
    io_wr(IDX, 8'ha5);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    nerr++;
    $display("FAIL R10: actual run still going expected finished by watchdog");
    summary();
  end

  initial begin
    logic [7:0]  v;
    logic [31:0] a, d, e;
    int          t0;
    repeat (3) @(negedge clk_i);
    #1 chk("R1 ready", 32'(h_ready_o), 32'd1);
    chk("R1 req", 32'(m_req_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1 chk("R1 ready after release", 32'(h_ready_o), 32'd1);

    // R2: locked window
    io_rd(DAT, v); chk("R2 locked data read", 32'(v), 32'd0);
    io_wr(IDX, 8'h07); io_wr(DAT, 8'h0d);
    io_wr(IDX, 8'ha5); io_wr(IDX, 8'h07); io_wr(IDX, 8'ha5);
    io_wr(IDX, 8'h07);                              // breaks the pair
    io_rd(DAT, v); chk("R2 broken pair still locked", 32'(v), 32'd0);
    io_wr(DAT, 8'h0d);
    io_rd(IDX, v); chk("R2 locked index read", 32'(v), 32'd0);
    unlock();
    io_rd(IDX, v); chk("R2 index readback", 32'(v), 32'h0000_00a5);
    reg_rd(8'h07, v); chk("R2 locked writes dropped / R1 ldn reset", 32'(v), 32'd0);

    // R4: device gating
    reg_wr(8'h07, 8'h0c);
    reg_wr(8'hf0, 8'h55);
    reg_rd(8'hf0, v); chk("R4 wrong device read", 32'(v), 32'd0);
    reg_wr(8'h07, 8'h0d);
    reg_rd(8'h07, v); chk("R4 ldn readback", 32'(v), 32'h0d);
    reg_rd(8'hf0, v); chk("R4 write under wrong device dropped", 32'(v), 32'd0);
    reg_rd(8'hf8, v); chk("R1 size reset", 32'(v), 32'd0);

    // R5: enable
    reg_rd(8'h30, v); chk("R5 enable reset", 32'(v), 32'd0);
    t0 = ntx;
    reg_wr(8'hfe, 8'hcf);
    reg_rd(8'hfe, v);
    repeat (4) @(negedge clk_i);
    chk("R5 disabled triggers", 32'(ntx - t0), 32'd0);
    chk("R5 disabled ready", 32'(h_ready_o), 32'd1);
    reg_wr(8'h30, 8'hff);
    reg_rd(8'h30, v); chk("R5 enable bit only", 32'(v), 32'd1);

    // R7: wrong trigger code
    t0 = ntx;
    reg_wr(8'hfe, 8'h5a);
    repeat (4) @(negedge clk_i);
    chk("R7 non-key trigger", 32'(ntx - t0), 32'd0);

    // R6: address lanes readback
    for (int b = 0; b < 4; b++) reg_wr(8'hf0 + 8'(b), 8'h11 * 8'(b + 1));
    for (int b = 0; b < 4; b++) begin
      reg_rd(8'hf0 + 8'(b), v);
      chk("R6 address byte readback", 32'(v), 32'(8'h11 * 8'(b + 1)));
    end

    // sweep: latency x size x pattern
    for (int li = 0; li < 4; li++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int k = 0; k < 3; k++) begin
          lat = li;
          a = 32'h8000_0000 + 32'(li) * 32'h0101_0300 + 32'(sz) * 32'h0000_0044 + 32'(k) * 32'h0012_3408;
          d = (a ^ 32'hdead_beef) + 32'(k * 7);
          reg_wr(8'hf8, 8'(sz));
          for (int b = 0; b < 4; b++) reg_wr(8'hf0 + 8'(b), a[31-8*b -: 8]);
          for (int b = 0; b < 4; b++) reg_wr(8'hf4 + 8'(b), d[31-8*b -: 8]);
          t0 = ntx;
          reg_wr(8'hfe, 8'hcf);
          #1 chk("R10 ready low during write", 32'(h_ready_o), 32'd0);
          chk("R7 request raised", 32'(m_req_o), 32'd1);
          wait_idle();
          chk("R7 one write", 32'(ntx - t0), 32'd1);
          chk("R7 write address", cap_addr, a);
          chk("R7 write dir", 32'(cap_we), 32'd1);
          chk("R9 size out", 32'(cap_size), 32'(sz));
          chk("R9 write data mask", cap_wdata, d & msk(sz));
          t0 = ntx;
          reg_rd(8'hfe, v);
          chk("R8 trigger read value", 32'(v), 32'd0);
          wait_idle();
          chk("R8 one read", 32'(ntx - t0), 32'd1);
          chk("R8 read dir", 32'(cap_we), 32'd0);
          chk("R8 read address", cap_addr, a);
          e = model_rd(a) & msk(sz);
          for (int b = 0; b < 4; b++) begin
            reg_rd(8'hf4 + 8'(b), v);
            chk("R8 R9 read data byte", 32'(v), (e >> (24 - 8 * b)) & 32'hff);
          end
        end
      end
    end

    // R10: strobe during a busy cycle is ignored
    lat = 6;
    reg_wr(8'hf8, 8'd2);
    t0 = ntx;
    reg_wr(8'hfe, 8'hcf);
    h_addr_i = DAT; h_wdata_i = 8'hcf; h_wr_i = 1'b1;
    @(negedge clk_i);
    h_wr_i = 1'b0;
    wait_idle();
    repeat (10) @(negedge clk_i);
    chk("R10 stalled strobe ignored", 32'(ntx - t0), 32'd1);
    chk("R10 no request after completion", 32'(m_req_o), 32'd0);
    lat = 0;

    // R3: relock
    reg_wr(8'hf1, 8'h3c);
    io_wr(IDX, 8'haa);
    io_rd(DAT, v); chk("R3 relocked read", 32'(v), 32'd0);
    io_wr(DAT, 8'hc3);                              // index still 0xaa; try staging too
    io_wr(IDX, 8'hf1); io_wr(DAT, 8'hc3);
    unlock();
    reg_rd(8'hf1, v); chk("R3 writes after relock dropped", 32'(v), 32'h3c);

    summary();
  end
endmodule